// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the timing skeleton of a fixed raster display. A position counter runs through every clock cycle of a scanline, and a line counter runs through every scanline of a frame. Both counts are decoded into an active-low line sync, an active-low frame sync, a qualifier that marks the visible pixel window, and a frame interrupt flag. The flag rises when the beam leaves the visible rows and falls again when the next frame begins.

The default geometry is 1024 cycles per line and 312 lines per frame. Line sync is low for the first 75 cycles of each line. Frame sync starts at the top of the frame and is released halfway along line 2. The visible window covers lines 38 to 293 and positions 256 to 895. Every edge is a parameter. The outputs are registered and decoded from the counters' next values, so each output always agrees with the `pos` and `line` values shown in the same cycle. Downstream fetch and pixel logic can use these signals directly.

Top module: `raster_sync_gen`

## Requirements
- R1: `pos` counts up by one each clock from 0 to LINE_LEN-1 (default 1023), then returns to 0 on the next clock.
- R2: `line` holds its value while `pos` counts. It increments in the cycle in which `pos` returns to 0. After FRAME_LINES-1 (default 311) it returns to 0.
- R3: `hsync_n` is 0 exactly while `pos` is below HS_END (default 75) and 1 otherwise, on every line.
- R4: `vsync_n` is 0 from line 0, position 0, up to but not including line VS_END_LINE, position VS_END_POS (default line 2, position 512). It is 1 everywhere else in the frame.
- R5: `active` is 0 on every line outside ACT_FIRST_LINE..ACT_LAST_LINE (default 38..293 inclusive).
- R6: On lines inside that range, `active` is 1 exactly while `pos` is within ACT_FIRST_POS..ACT_LAST_POS (default 256..895 inclusive).
- R7: `frame_irq` becomes 1 in the cycle where `line` first shows IRQ_LINE (default 294). It stays 1 until the cycle where `line` shows 0, and it becomes 0 in that cycle.
- R8: A synchronous active-low reset sets `pos` and `line` to 0, drives `hsync_n`, `vsync_n`, `active` and `frame_irq` to 0, and restarts the frame from the top. This applies even when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| active | output | 1 | High inside the visible pixel window |
| frame_irq | output | 1 | Frame interrupt request flag |
| pos | output | $clog2(LINE_LEN) | Position within the current line |
| line | output | $clog2(FRAME_LINES) | Current line within the frame |

## Verification
At the top of a frame, several events land on one clock edge: the line counter wraps to 0, line sync falls, frame sync falls and the interrupt flag clears. The last line of the visible window and the interrupt line are also adjacent, so the flag rises on the edge where `active` has already stopped. These coincidences are provoked by running a scaled-down instance through a whole frame and past its wrap. Every output is compared on every cycle against a model indexed by the cycle count since reset. A second instance at the default geometry is run over its first three lines to confirm the line sync edges and the half-line release of frame sync.

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
  parameter int LINE_LEN       = 1024,
  parameter int FRAME_LINES    = 312,
  parameter int HS_END         = 75,
  parameter int VS_END_LINE    = 2,
  parameter int VS_END_POS     = 512,
  parameter int ACT_FIRST_LINE = 38,
  parameter int ACT_LAST_LINE  = 293,
  parameter int ACT_FIRST_POS  = 256,
  parameter int ACT_LAST_POS   = 895,
  parameter int IRQ_LINE       = 294,
  localparam int POS_W  = $clog2(LINE_LEN),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              active,
  output logic              frame_irq,
  output logic [POS_W-1:0]  pos,
  output logic [LINE_W-1:0] line
);

  logic [POS_W-1:0]  pos_q, pos_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              end_of_line, end_of_frame;
  logic              hs_q, vs_q, act_q, irq_q;
  logic              hs_d, vs_d, act_d;
  logic              row_vis, col_vis;

  assign end_of_line  = pos_q == POS_W'(LINE_LEN - 1);
  assign end_of_frame = line_q == LINE_W'(FRAME_LINES - 1);

  assign pos_d  = end_of_line ? '0 : pos_q + 1'b1;
  assign line_d = !end_of_line ? line_q : (end_of_frame ? '0 : line_q + 1'b1);

  assign hs_d = pos_d >= POS_W'(HS_END);
  assign vs_d = (line_d > LINE_W'(VS_END_LINE)) ||
                (line_d == LINE_W'(VS_END_LINE) && pos_d >= POS_W'(VS_END_POS));

  assign row_vis = line_d >= LINE_W'(ACT_FIRST_LINE) && line_d <= LINE_W'(ACT_LAST_LINE);
  assign col_vis = pos_d >= POS_W'(ACT_FIRST_POS) && pos_d <= POS_W'(ACT_LAST_POS);
  assign act_d   = row_vis && col_vis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      line_q <= '0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      line_q <= line_d;
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      act_q  <= act_d;
      if (end_of_line && line_d == LINE_W'(IRQ_LINE))
        irq_q <= 1'b1;
      else if (end_of_line && line_d == '0)
        irq_q <= 1'b0;
    end
  end

  assign pos       = pos_q;
  assign line      = line_q;
  assign hsync_n   = hs_q;
  assign vsync_n   = vs_q;
  assign active    = act_q;
  assign frame_irq = irq_q;

endmodule

// File: rtl/raster_sync_gen_checker.sv
module raster_sync_gen_checker #(
  parameter int LINE_LEN       = 1024,
  parameter int FRAME_LINES    = 312,
  parameter int HS_END         = 75,
  parameter int VS_END_LINE    = 2,
  parameter int VS_END_POS     = 512,
  parameter int ACT_FIRST_LINE = 38,
  parameter int ACT_LAST_LINE  = 293,
  parameter int ACT_FIRST_POS  = 256,
  parameter int ACT_LAST_POS   = 895,
  parameter int IRQ_LINE       = 294,
  localparam int POS_W  = $clog2(LINE_LEN),
  localparam int LINE_W = $clog2(FRAME_LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_n,
  input logic              vsync_n,
  input logic              active,
  input logic              frame_irq,
  input logic [POS_W-1:0]  pos,
  input logic [LINE_W-1:0] line
);

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pos == POS_W'(LINE_LEN - 1) |=> pos == '0); // R1

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pos != POS_W'(LINE_LEN - 1) |=> pos == POS_W'($past(pos) + 1'b1)); // R1

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pos != POS_W'(LINE_LEN - 1) |=> $stable(line)); // R2

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pos == POS_W'(LINE_LEN - 1) && line == LINE_W'(FRAME_LINES - 1) |=> line == '0); // R2

  AST_HS_FALL_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> pos == '0); // R3

  AST_HS_RISE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> pos == POS_W'(HS_END)); // R3

  AST_VS_RELEASE_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> line == LINE_W'(VS_END_LINE) && pos == POS_W'(VS_END_POS)); // R4

  AST_VS_FALL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n) |-> line == '0 && pos == '0); // R4

  AST_ACTIVE_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> line >= LINE_W'(ACT_FIRST_LINE) && line <= LINE_W'(ACT_LAST_LINE)); // R5

  AST_ACTIVE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> pos == POS_W'(ACT_FIRST_POS)); // R6

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> line == LINE_W'(IRQ_LINE) && pos == '0); // R7

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_irq) |-> line == '0 && pos == '0); // R7

endmodule

bind raster_sync_gen raster_sync_gen_checker #(
  .LINE_LEN(LINE_LEN), .FRAME_LINES(FRAME_LINES), .HS_END(HS_END),
  .VS_END_LINE(VS_END_LINE), .VS_END_POS(VS_END_POS),
  .ACT_FIRST_LINE(ACT_FIRST_LINE), .ACT_LAST_LINE(ACT_LAST_LINE),
  .ACT_FIRST_POS(ACT_FIRST_POS), .ACT_LAST_POS(ACT_LAST_POS),
  .IRQ_LINE(IRQ_LINE)
) u_checker (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .active(active), .frame_irq(frame_irq), .pos(pos), .line(line)
);

// File: tb/raster_sync_gen_bench.sv
module raster_sync_gen_bench;

  localparam int S_LEN = 64, S_LINES = 40, S_HS = 6, S_VL = 2, S_VP = 32;
  localparam int S_AL0 = 5, S_AL1 = 24, S_AP0 = 16, S_AP1 = 55, S_IRQ = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic       d_hs, d_vs, d_act, d_irq;
  logic [9:0] d_pos;
  logic [8:0] d_line;
  logic       s_hs, s_vs, s_act, s_irq;
  logic [5:0] s_pos;
  logic [5:0] s_line;

  raster_sync_gen u_raster_sync_gen (
    .clk(clk), .rst_n(rst_n), .hsync_n(d_hs), .vsync_n(d_vs),
    .active(d_act), .frame_irq(d_irq), .pos(d_pos), .line(d_line)
  );

  raster_sync_gen #(
    .LINE_LEN(S_LEN), .FRAME_LINES(S_LINES), .HS_END(S_HS),
    .VS_END_LINE(S_VL), .VS_END_POS(S_VP),
    .ACT_FIRST_LINE(S_AL0), .ACT_LAST_LINE(S_AL1),
    .ACT_FIRST_POS(S_AP0), .ACT_LAST_POS(S_AP1), .IRQ_LINE(S_IRQ)
  ) u_small (
    .clk(clk), .rst_n(rst_n), .hsync_n(s_hs), .vsync_n(s_vs),
    .active(s_act), .frame_irq(s_irq), .pos(s_pos), .line(s_line)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_point(int k, int L, int N, int hs, int vl, int vp,
                             int al0, int al1, int ap0, int ap1, int il,
                             int a_pos, int a_line, int a_hs, int a_vs,
                             int a_act, int a_irq);
    int p = k % L;
    int l = (k / L) % N;
    int e_vs = (l > vl || (l == vl && p >= vp)) ? 1 : 0;
    int e_act = (l >= al0 && l <= al1 && p >= ap0 && p <= ap1) ? 1 : 0;
    chk("R1", "pos", a_pos, p);
    chk("R2", "line", a_line, l);
    chk("R3", "hsync_n", a_hs, (p >= hs) ? 1 : 0);
    chk("R4", "vsync_n", a_vs, e_vs);
    if (l < al0 || l > al1) chk("R5", "active off-row", a_act, 0);
    else                    chk("R6", "active in-row", a_act, e_act);
    chk("R7", "frame_irq", a_irq, (l >= il) ? 1 : 0);
  endtask

  task automatic check_reset_state(string tag);
    chk("R8", {tag, " pos"}, int'(s_pos) + int'(d_pos), 0);
    chk("R8", {tag, " line"}, int'(s_line) + int'(d_line), 0);
    chk("R8", {tag, " hsync_n"}, int'(s_hs) + int'(d_hs), 0);
    chk("R8", {tag, " vsync_n"}, int'(s_vs) + int'(d_vs), 0);
    chk("R8", {tag, " active"}, int'(s_act) + int'(d_act), 0);
    chk("R8", {tag, " frame_irq"}, int'(s_irq) + int'(d_irq), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check_reset_state("after reset");
  endtask

  task automatic t_default_lines();
    do_reset();
    for (int k = 0; k < 3 * 1024 + 20; k++) begin
      check_point(k, 1024, 312, 75, 2, 512, 38, 293, 256, 895, 294,
                  int'(d_pos), int'(d_line), int'(d_hs), int'(d_vs),
                  int'(d_act), int'(d_irq));
      @(negedge clk);
    end
  endtask

  task automatic t_small_frame();
    do_reset();
    for (int k = 0; k < S_LEN * S_LINES + 3 * S_LEN; k++) begin
      check_point(k, S_LEN, S_LINES, S_HS, S_VL, S_VP, S_AL0, S_AL1,
                  S_AP0, S_AP1, S_IRQ,
                  int'(s_pos), int'(s_line), int'(s_hs), int'(s_vs),
                  int'(s_act), int'(s_irq));
      @(negedge clk);
    end
  endtask

  task automatic t_reset_midframe();
    do_reset();
    repeat ((S_IRQ + 1) * S_LEN + 5) @(negedge clk);
    chk("R7", "irq before mid-frame reset", int'(s_irq), 1);
    chk("R6", "small active before reset", int'(s_act), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("mid-frame reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "restart pos", int'(s_pos), 1);
    chk("R8", "restart line", int'(s_line), 0);
  endtask

  initial begin
    t_reset_state();
    t_default_lines();
    t_small_frame();
    t_reset_midframe();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule